// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through SRAM Core

A synchronous single-port static memory whose host may switch between reading and writing on every clock with no idle cycle between them. On each rising edge with clock enable active the block registers a command: three chip selects, a load/advance control, a write enable and one write enable per byte lane. A read is flow-through, so its data is on the output during the cycle that follows the edge that registered the address. A write takes its data one enabled edge after its address.

Write data does not go to the array straight away. It is parked in a pending-write register for one more enabled edge, and the array is written from there. A read of the parked address merges the parked bytes over the array word, lane by lane. Bursts of four beats follow a linear or an interleaved order, selected by a pin. The address sequence comes from a separate generator. The output pad is modelled as a data bus plus a drive-enable flag, gated by an asynchronous output enable.

Top module: `zt_sram`

## Requirements
- R1: A read command registered on an enabled edge drives the addressed word on `rdata` with `rdata_oe` high in the cycle after that edge, when `oe_n` is low.
- R2: Write data for a write command is taken from `wdata` on the next enabled edge after the command. Lane i is bits [8i+7:8i].
- R3: With `adv` low and all selects active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0), a new cycle begins at `addr`. `wr_n`=0 starts a write and `wr_n`=1 starts a read.
- R4: With `adv` low and any select inactive, the block is deselected and `rdata_oe` is low. With `adv` high, a deselected block stays deselected whatever the selects are.
- R5: With `adv` high, the current read or write moves to the next burst address. Only the two low address bits change. With `burst_linear`=1 they step as base+n mod 4; with `burst_linear`=0 they step as base XOR n.
- R6: A write with every `lane_we_n` bit high is an abort. No byte changes and the output stays undriven.
- R7: Only lanes whose `lane_we_n` bit is low are written. The other lanes keep their contents.
- R8: An edge with `clk_en_n` high is ignored: no state, address or write changes. A read that is driving keeps driving the same word.
- R9: `rdata_oe` is high only in a read cycle with `oe_n` low, and it follows `oe_n` with no clock. `rdata` is zero while `rdata_oe` is low.
- R10: A read of the address held in the pending-write register returns the pending lanes merged over the array word. This includes a read issued right after the write's data edge.
- R11: A pending write reaches the array even when a deselect or an abort follows it.
- R12: Synchronous reset (`rst`=1) deselects the block and discards any write whose data has not yet reached the array.
- R13: Read and write commands may alternate on consecutive edges with no idle cycle, and each read returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load a new command, 1 = advance the burst |
| wr_n | input | 1 | 0 = write, 1 = read |
| lane_we_n | input | DATA_W/LANE_W | Per-lane write enable, active low |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data, one enabled edge after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Output drive enable |

## Verification
Two functions can fall in the same cycle: the commit of the pending write to the array and a flow-through read of that same word. The bench provokes this by issuing a partial-lane write and then, on the very next edge, a read of the same address. That edge carries the write data, so the read must be served by the merge path. The word is then read again after the commit, and a stalled write is followed at once by a read of its address. In each case the bench judges the output against byte-merged values worked out by hand.

// File: rtl/zt_pkg.sv
package zt_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq #(
   parameter int OFS_W = 2
) (
   input  logic [OFS_W-1:0] base_lo,
   input  logic [OFS_W-1:0] step,
   input  logic             linear,
   output logic [OFS_W-1:0] ofs
);
   initial begin
      if (OFS_W < 1) $fatal(1, "zt_burst_seq: OFS_W must be at least 1");
   end

   logic [OFS_W-1:0] lin_ofs;
   logic [OFS_W-1:0] ilv_ofs;

   assign lin_ofs = base_lo + step;
   assign ilv_ofs = base_lo ^ step;
   assign ofs     = linear ? lin_ofs : ilv_ofs;
endmodule

// File: rtl/zt_lane_merge.sv
module zt_lane_merge #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic [DATA_W-1:0] base_word,
   input  logic [DATA_W-1:0] over_word,
   input  logic [LANES-1:0]  lane_sel,
   output logic [DATA_W-1:0] merged
);
   initial begin
      if (DATA_W % LANE_W != 0) $fatal(1, "zt_lane_merge: DATA_W not a multiple of LANE_W");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*LANE_W +: LANE_W] = lane_sel[g] ? over_word[g*LANE_W +: LANE_W]
                                                     : base_word[g*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/zt_pend_buf.sv
module zt_pend_buf #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_en,
   input  logic              cmd_wr,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LANES-1:0]  cmd_lanes,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] arr_word,
   output logic              commit_en,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [LANES-1:0]  commit_lanes,
   output logic [DATA_W-1:0] commit_data,
   output logic [DATA_W-1:0] rd_word
);
   // address stage: command accepted, data not yet here
   logic              wc_valid;
   logic [ADDR_W-1:0] wc_addr;
   logic [LANES-1:0]  wc_lanes;
   // data stage: complete write waiting for the array
   logic              pend_valid;
   logic [ADDR_W-1:0] pend_addr;
   logic [LANES-1:0]  pend_lanes;
   logic [DATA_W-1:0] pend_data;
   logic              hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         wc_valid   <= 1'b0;
         pend_valid <= 1'b0;
      end else if (step_en) begin
         wc_valid   <= cmd_wr && (|cmd_lanes);
         wc_addr    <= cmd_addr;
         wc_lanes   <= cmd_lanes;
         pend_valid <= wc_valid;
         pend_addr  <= wc_addr;
         pend_lanes <= wc_lanes;
         pend_data  <= wdata;
      end
   end

   assign commit_en    = step_en && pend_valid && !rst;
   assign commit_addr  = pend_addr;
   assign commit_lanes = pend_lanes;
   assign commit_data  = pend_data;

   assign hit = pend_valid && (pend_addr == rd_addr);

   zt_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_fwd (
      .base_word (arr_word),
      .over_word (pend_data),
      .lane_sel  (hit ? pend_lanes : '0),
      .merged    (rd_word)
   );

   // R12
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> (!pend_valid && !wc_valid));

   // R6
   abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && cmd_wr && (cmd_lanes == '0)) |=> !wc_valid);

   // R2
   data_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && wc_valid) |=> (pend_valid && pend_data == $past(wdata)));

   // R8
   stall_pend_chk: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> ($stable(wc_valid) && $stable(pend_valid)));
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
   parameter int DATA_W  = 32,
   parameter int LANE_W  = 8,
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2,
   localparam int LANES  = DATA_W / LANE_W,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clk_en_n,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              adv,
   input  logic              wr_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic              burst_linear,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              oe_n,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);
   import zt_pkg::*;

   initial begin
      if (DATA_W % LANE_W != 0) $fatal(1, "zt_sram: DATA_W not a multiple of LANE_W");
      if (BURST_W < 1 || BURST_W >= ADDR_W) $fatal(1, "zt_sram: BURST_W out of range");
   end

   op_e               op, nxt_op;
   logic [ADDR_W-1:0] base_addr, nxt_base;
   logic [BURST_W-1:0] step_cnt, nxt_step;
   logic [BURST_W-1:0] cur_ofs, nxt_ofs;
   logic [ADDR_W-1:0] cur_addr, nxt_addr;
   logic              all_sel, step_en;
   logic              commit_en;
   logic [ADDR_W-1:0] commit_addr;
   logic [LANES-1:0]  commit_lanes;
   logic [DATA_W-1:0] commit_data;
   logic [DATA_W-1:0] arr_word, rd_word;
   logic [DATA_W-1:0] mem [DEPTH];

   assign all_sel = !sel_a_n && sel_b && !sel_c_n;
   assign step_en = !clk_en_n;

   always_comb begin
      nxt_op   = op;
      nxt_base = base_addr;
      nxt_step = step_cnt;
      if (!adv) begin
         if (all_sel) begin
            nxt_op   = wr_n ? OP_READ : OP_WRITE;
            nxt_base = addr;
            nxt_step = '0;
         end else begin
            nxt_op = OP_IDLE;
         end
      end else if (op != OP_IDLE) begin
         nxt_step = step_cnt + BURST_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         op        <= OP_IDLE;
         base_addr <= '0;
         step_cnt  <= '0;
      end else if (step_en) begin
         op        <= nxt_op;
         base_addr <= nxt_base;
         step_cnt  <= nxt_step;
      end
   end

   zt_burst_seq #(.OFS_W(BURST_W)) u_cur_seq (
      .base_lo (base_addr[BURST_W-1:0]),
      .step    (step_cnt),
      .linear  (burst_linear),
      .ofs     (cur_ofs)
   );

   zt_burst_seq #(.OFS_W(BURST_W)) u_nxt_seq (
      .base_lo (nxt_base[BURST_W-1:0]),
      .step    (nxt_step),
      .linear  (burst_linear),
      .ofs     (nxt_ofs)
   );

   assign cur_addr = {base_addr[ADDR_W-1:BURST_W], cur_ofs};
   assign nxt_addr = {nxt_base[ADDR_W-1:BURST_W], nxt_ofs};

   zt_pend_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_pend (
      .clk          (clk),
      .rst          (rst),
      .step_en      (step_en),
      .cmd_wr       (nxt_op == OP_WRITE),
      .cmd_addr     (nxt_addr),
      .cmd_lanes    (~lane_we_n),
      .wdata        (wdata),
      .rd_addr      (cur_addr),
      .arr_word     (arr_word),
      .commit_en    (commit_en),
      .commit_addr  (commit_addr),
      .commit_lanes (commit_lanes),
      .commit_data  (commit_data),
      .rd_word      (rd_word)
   );

   always_ff @(posedge clk) begin
      if (commit_en) begin
         for (int l = 0; l < LANES; l++) begin
            if (commit_lanes[l]) mem[commit_addr][l*LANE_W +: LANE_W] <= commit_data[l*LANE_W +: LANE_W];
         end
      end
   end

   assign arr_word = mem[cur_addr];
   assign rdata_oe = (op == OP_READ) && !oe_n;
   assign rdata    = rdata_oe ? rd_word : '0;

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      clk_en_n |=> ($stable(op) && $stable(cur_addr)));

   // R4
   deselect_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && !adv && !all_sel) |=> (op == OP_IDLE && !rdata_oe));

   // R3
   begin_read_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && !adv && all_sel && wr_n) |=> (op == OP_READ && cur_addr == $past(addr)));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && adv && op == OP_IDLE) |=> (op == OP_IDLE));
endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/100ps
module zt_sram_tb;
   logic        clk = 1'b0;
   logic        rst, clk_en_n, sel_a_n, sel_b, sel_c_n, adv, wr_n, burst_linear, oe_n;
   logic [3:0]  lane_we_n;
   logic [5:0]  addr;
   logic [31:0] wdata, rdata;
   logic        rdata_oe;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   always #2.5 clk = ~clk;

   zt_sram u_dut (
      .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
      .sel_c_n(sel_c_n), .adv(adv), .wr_n(wr_n), .lane_we_n(lane_we_n),
      .burst_linear(burst_linear), .addr(addr), .wdata(wdata), .oe_n(oe_n),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );

   // fields: en | sel | adv | wr_n | lane_we_n[4] | addr[6] | wdata[32] | exp_oe | exp_data[32]
   localparam int NV = 17;
   localparam logic [78:0] VEC [NV] = '{
      {1'b1,1'b1,1'b0,1'b0,4'b0000,6'h04,32'h00000000,1'b0,32'h00000000},
      {1'b1,1'b1,1'b0,1'b0,4'b0000,6'h05,32'h11111111,1'b0,32'h00000000},
      {1'b1,1'b1,1'b0,1'b0,4'b0000,6'h06,32'h22222222,1'b0,32'h00000000},
      {1'b1,1'b1,1'b0,1'b1,4'b1111,6'h04,32'h33333333,1'b1,32'h11111111},
      {1'b1,1'b1,1'b0,1'b0,4'b1010,6'h06,32'h00000000,1'b0,32'h00000000},
      {1'b1,1'b1,1'b0,1'b1,4'b1111,6'h06,32'hA0B0C0D0,1'b1,32'h33B033D0},
      {1'b1,1'b1,1'b0,1'b1,4'b1111,6'h05,32'h00000000,1'b1,32'h22222222},
      {1'b1,1'b1,1'b0,1'b1,4'b1111,6'h06,32'h00000000,1'b1,32'h33B033D0},
      {1'b1,1'b1,1'b0,1'b0,4'b1111,6'h04,32'h00000000,1'b0,32'h00000000},
      {1'b1,1'b1,1'b0,1'b1,4'b1111,6'h04,32'hDEADBEEF,1'b1,32'h11111111},
      {1'b1,1'b0,1'b0,1'b1,4'b1111,6'h04,32'h00000000,1'b0,32'h00000000},
      {1'b1,1'b1,1'b1,1'b1,4'b1111,6'h04,32'h00000000,1'b0,32'h00000000},
      {1'b1,1'b1,1'b0,1'b0,4'b0000,6'h07,32'h00000000,1'b0,32'h00000000},
      {1'b1,1'b1,1'b0,1'b1,4'b1111,6'h05,32'h77777777,1'b1,32'h22222222},
      {1'b1,1'b1,1'b1,1'b1,4'b1111,6'h00,32'h00000000,1'b1,32'h33B033D0},
      {1'b1,1'b1,1'b1,1'b1,4'b1111,6'h00,32'h00000000,1'b1,32'h77777777},
      {1'b1,1'b1,1'b1,1'b1,4'b1111,6'h00,32'h00000000,1'b1,32'h11111111}
   };

   function automatic string vec_tag(int i);
      case (i)
         0, 1, 2, 4:  return "R2/R3 write";
         3, 6:        return "R1/R13 read";
         5:           return "R10/R7 forward merge";
         7:           return "R7 lane merge in array";
         8, 9:        return "R6 abort";
         10:          return "R4 deselect";
         11:          return "R4 continue deselect";
         12, 13:      return "R13 mixed";
         default:     return "R5 linear burst";
      endcase
   endfunction

   task automatic drive(input logic en, input logic [2:0] sels, input logic a, input logic w,
                        input logic [3:0] ln, input logic [5:0] ad, input logic [31:0] wd);
      clk_en_n  = !en;
      sel_a_n   = sels[2];
      sel_b     = sels[1];
      sel_c_n   = sels[0];
      adv       = a;
      wr_n      = w;
      lane_we_n = ln;
      addr      = ad;
      wdata     = wd;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input logic eo, input logic [31:0] ed);
      checks++;
      if (rdata_oe !== eo || rdata !== ed) begin
         errors++;
         $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", tag, rdata_oe, rdata, eo, ed);
      end
   endtask

   localparam logic [2:0] SEL_ON = 3'b010;

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; oe_n = 1'b0; burst_linear = 1'b1;
      clk_en_n = 1'b0; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1; adv = 1'b0;
      wr_n = 1'b1; lane_we_n = 4'hF; addr = '0; wdata = '0;
      repeat (2) @(posedge clk);
      #1;
      check("R12 reset state", 1'b0, 32'h0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][78], VEC[i][77] ? SEL_ON : 3'b000, VEC[i][76], VEC[i][75],
               VEC[i][74:71], VEC[i][70:65], VEC[i][64:33]);
         check(vec_tag(i), VEC[i][32], VEC[i][31:0]);
      end

      // R5 interleaved order from low bits 01: 5,4,7,6
      burst_linear = 1'b0;
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h05, 32'h0); check("R5 interleaved beat0", 1, 32'h22222222);
      drive(1, SEL_ON, 1, 1, 4'hF, 6'h00, 32'h0); check("R5 interleaved beat1", 1, 32'h11111111);
      drive(1, SEL_ON, 1, 1, 4'hF, 6'h00, 32'h0); check("R5 interleaved beat2", 1, 32'h77777777);
      drive(1, SEL_ON, 1, 1, 4'hF, 6'h00, 32'h0); check("R5 interleaved beat3", 1, 32'h33B033D0);
      burst_linear = 1'b1;

      // R5 burst write 08,09,0A
      drive(1, SEL_ON, 0, 0, 4'h0, 6'h08, 32'h0);
      drive(1, SEL_ON, 1, 0, 4'h0, 6'h00, 32'h80808080); check("R5 burst write bus idle", 0, 32'h0);
      drive(1, SEL_ON, 1, 0, 4'h0, 6'h00, 32'h81818181);
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h09, 32'h82828282); check("R5 burst write beat1", 1, 32'h81818181);
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h0A, 32'h0); check("R5 burst write beat2", 1, 32'h82828282);
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h08, 32'h0); check("R5 burst write beat0", 1, 32'h80808080);

      // R8 stall during a read
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h04, 32'h0); check("R8 read before stall", 1, 32'h11111111);
      drive(0, SEL_ON, 0, 0, 4'h0, 6'h05, 32'hBAD0BAD0); check("R8 stall keeps read", 1, 32'h11111111);
      drive(1, SEL_ON, 1, 1, 4'hF, 6'h00, 32'h0); check("R8 burst resumes", 1, 32'h22222222);

      // R8 stall during a write, R10 read right after data edge
      drive(1, SEL_ON, 0, 0, 4'h0, 6'h0B, 32'h0);
      drive(0, SEL_ON, 0, 1, 4'hF, 6'h04, 32'hBADBAD00); check("R8 stall in write undriven", 0, 32'h0);
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h0B, 32'h0B0B0B0B); check("R10 forward after stall", 1, 32'h0B0B0B0B);

      // R9 asynchronous output enable
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h04, 32'h0);
      oe_n = 1'b1; #1; check("R9 oe high blocks", 0, 32'h0);
      oe_n = 1'b0; #1; check("R9 oe low drives", 1, 32'h11111111);

      // R11 pending write survives deselects
      drive(1, SEL_ON, 0, 0, 4'h0, 6'h0C, 32'h0);
      drive(1, 3'b011, 0, 1, 4'hF, 6'h00, 32'hC0C0C0C0); check("R11 deselect by third select", 0, 32'h0);
      drive(1, 3'b110, 0, 1, 4'hF, 6'h00, 32'h0); check("R4 deselect by first select", 0, 32'h0);
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h0C, 32'h0); check("R11 data kept over deselect", 1, 32'hC0C0C0C0);

      // R12 reset drops a write whose data has not reached the array
      drive(1, SEL_ON, 0, 0, 4'h0, 6'h0D, 32'h0);
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h04, 32'hD1D1D1D1);
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h04, 32'h0);
      drive(1, SEL_ON, 0, 0, 4'h0, 6'h0D, 32'h0);
      rst = 1'b1;
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h04, 32'hEEEEEEEE); check("R12 reset deselects", 0, 32'h0);
      rst = 1'b0;
      drive(1, SEL_ON, 0, 1, 4'hF, 6'h0D, 32'h0); check("R12 reset dropped write", 1, 32'hD1D1D1D1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule